// File: doc/BRIEF.md
# Serial CSR Stream Fetch Controller

This block walks a sparse matrix held in compressed-sparse-row layout and delivers, one element at a time, the nonzero value together with the dense-vector entry its column selects, plus a row label, to a downstream multiply-accumulate unit. It owns three read ports. The first goes to a row-offset RAM (one cycle of read latency). The second goes to a pair memory in which each address holds one matrix element; the column index and the value are fetched with two reads on consecutive cycles and return after a fixed latency. The third goes to the vector RAM (one cycle of read latency), and its address is the returned column index.

A sequencer reads two neighbouring row offsets and subtracts them to obtain the row length. It then alternates column and value reads for each element of the row, so at most one element is issued every two cycles. Each element's label (its count of elements still to come in the row, itself included) travels through a delay line that matches the memory latencies, so the label reaches the output together with the value and its vector entry. A row with no elements still yields one marked output, which keeps the downstream per-row result count regular. A done flag accompanies the final output of the matrix.

Top module: `csr_stream_fetch`

## Requirements
- R1: After reset, and until `start` is taken, `ptr_en`, `pair_en`, `vec_en`, `out_valid` and `out_done` are all low.
- R2: A `start` pulse with `num_rows` equal to zero is ignored: no memory read is issued and no output appears.
- R3: Row r has length offset[r+1] − offset[r]. A nonempty row yields exactly that many outputs, in address order starting at offset[r], and `out_value` equals the value stored at that pair address.
- R4: `out_vec` equals the vector RAM word at the column index stored with the same element. The column read (`pair_sel` = 0) of an address always precedes its value read (`pair_sel` = 1) by one cycle.
- R5: Element j (counted from 0) of a row of length L carries `out_label` = L − j, so the last element of every row carries label 1 and no valid output has label 0.
- R6: A row of length zero yields exactly one output with `out_empty` = 1, `out_value` = 0, `out_vec` = 0 and `out_label` = 1. Outputs of nonempty rows have `out_empty` = 0.
- R7: Within a row, successive outputs are exactly two cycles apart, and two value reads are never issued on adjacent cycles.
- R8: With `start` sampled high at the rising edge that ends cycle n, the first output of the matrix is valid in cycle n+17. The first output of each later row follows the previous row's final output by 5 cycles when that previous row is nonempty and by 4 cycles when it is empty.
- R9: `out_done` is high for exactly one cycle, together with the final output of the matrix. After that the controller accepts a new `start`.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass over the matrix |
| num_rows | input | ROW_W | Number of matrix rows, sampled with `start` |
| ptr_en | output | 1 | Row-offset RAM read enable |
| ptr_addr | output | ROW_W | Row-offset RAM address |
| ptr_rdata | input | NNZ_W | Row-offset RAM data, one cycle after the read |
| pair_en | output | 1 | Pair memory read enable |
| pair_sel | output | 1 | 0 selects the column half, 1 the value half |
| pair_addr | output | NNZ_W | Pair memory element address |
| pair_rvalid | input | 1 | Pair memory return strobe, PAIR_LAT cycles after a read |
| pair_rdata | input | PAIR_W | Pair memory return data; the column sits in the low COL_W bits |
| vec_en | output | 1 | Vector RAM read enable |
| vec_addr | output | COL_W | Vector RAM address (the returned column) |
| vec_rdata | input | VEC_W | Vector RAM data, VEC_LAT cycles after the read |
| out_valid | output | 1 | Output element present |
| out_value | output | VAL_W | Matrix value |
| out_vec | output | VEC_W | Matching vector entry |
| out_label | output | NNZ_W | Elements still due in this row, including this one |
| out_empty | output | 1 | Marker output for a row with no elements |
| out_done | output | 1 | Final output of the matrix |

## Verification
Every output is due in a cycle the bench works out arithmetically: 17 cycles after the `start` cycle for the first row, two cycles between elements of a row, and a gap of 5 or 4 cycles between rows, depending on whether the previous row had elements. The bench works out the expected cycle of each output before it starts a run. It samples on the falling edge, counts cycles from the `start` cycle, and reports any output that arrives early, late, with wrong contents, or that was not expected. The memory models in the bench apply the same ten-cycle and one-cycle latencies that the delay line in the design is sized for. A mismatch between these latencies therefore shows up as a wrong value or vector entry, not only as a wrong cycle.

// File: rtl/csr_fetch_pkg.sv
package csr_fetch_pkg;

   // Sequencer states; the ordering mirrors the walk through a row.
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,   // reset / waiting for start
      ST_WAIT   = 3'd1,   // settle slot ahead of the first offset read
      ST_PTR_LO = 3'd2,   // read offset of the current row
      ST_PTR_HI = 3'd3,   // read offset of the next row, latch the low one
      ST_LEN    = 3'd4,   // subtract, choose element walk or empty row
      ST_COL    = 3'd5,   // issue column half of an element
      ST_VAL    = 3'd6,   // issue value half, advance element address
      ST_EMPTY  = 3'd7    // emit marker for a row without elements
   } seq_state_e;

endpackage

// File: rtl/csr_delay_line.sv
module csr_delay_line #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("csr_delay_line: DEPTH must be at least 1");
   end

   logic [W-1:0] stage_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[DEPTH-1];

endmodule

// File: rtl/csr_row_seq.sv
module csr_row_seq
   import csr_fetch_pkg::*;
#(
   parameter int ROW_W = 8,
   parameter int NNZ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ROW_W-1:0] num_rows,
   output logic             ptr_en,
   output logic [ROW_W-1:0] ptr_addr,
   input  logic [NNZ_W-1:0] ptr_rdata,
   output logic             pair_en,
   output logic             pair_sel,
   output logic [NNZ_W-1:0] pair_addr,
   output logic [NNZ_W-1:0] tag_label,
   output logic             tag_empty,
   output logic             tag_last
);

   localparam logic [NNZ_W-1:0] LBL_ONE = NNZ_W'(1);

   seq_state_e       state_q, state_d;
   logic [ROW_W-1:0] row_q;      // index of the row being walked (+1 after ST_PTR_HI)
   logic [ROW_W-1:0] rows_q;     // row count latched at start
   logic [NNZ_W-1:0] lo_q;       // offset of the current row
   logic [NNZ_W-1:0] cnt_q;      // elements still to issue in the row
   logic [NNZ_W-1:0] addr_q;     // element address in the pair memory
   logic [NNZ_W-1:0] row_len;
   logic             last_row;

   assign row_len  = ptr_rdata - lo_q;
   assign last_row = (row_q == rows_q);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (start && (num_rows != '0)) state_d = ST_WAIT;
         ST_WAIT:   state_d = ST_PTR_LO;
         ST_PTR_LO: state_d = ST_PTR_HI;
         ST_PTR_HI: state_d = ST_LEN;
         ST_LEN:    state_d = (row_len != '0) ? ST_COL : ST_EMPTY;
         ST_COL:    state_d = ST_VAL;
         ST_VAL: begin
            if (cnt_q != '0)   state_d = ST_COL;
            else if (last_row) state_d = ST_IDLE;
            else               state_d = ST_PTR_LO;
         end
         ST_EMPTY:  state_d = last_row ? ST_IDLE : ST_PTR_LO;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         row_q   <= '0;
         rows_q  <= '0;
         lo_q    <= '0;
         cnt_q   <= '0;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  rows_q <= num_rows;
                  row_q  <= '0;
               end
            end
            ST_PTR_HI: begin
               lo_q  <= ptr_rdata;
               row_q <= row_q + 1'b1;
            end
            ST_LEN: begin
               cnt_q  <= row_len;
               addr_q <= lo_q;
            end
            ST_COL: cnt_q  <= cnt_q - 1'b1;
            ST_VAL: addr_q <= addr_q + 1'b1;
            default: ;
         endcase
      end
   end

   // Read ports
   assign ptr_en    = (state_q == ST_PTR_LO) || (state_q == ST_PTR_HI);
   assign ptr_addr  = (state_q == ST_PTR_HI) ? row_q + 1'b1 : row_q;
   assign pair_en   = (state_q == ST_COL) || (state_q == ST_VAL);
   assign pair_sel  = (state_q == ST_VAL);
   assign pair_addr = addr_q;

   // Tag entering the latency-matching delay line
   always_comb begin
      tag_label = '0;
      tag_empty = 1'b0;
      tag_last  = 1'b0;
      if (state_q == ST_COL) begin
         tag_label = cnt_q;
         tag_last  = last_row && (cnt_q == LBL_ONE);
      end else if (state_q == ST_EMPTY) begin
         tag_label = LBL_ONE;
         tag_empty = 1'b1;
         tag_last  = last_row;
      end
   end

endmodule

// File: rtl/csr_pair_align.sv
module csr_pair_align #(
   parameter int PAIR_W  = 32,
   parameter int COL_W   = 12,
   parameter int VAL_W   = 32,
   parameter int VEC_W   = 32,
   parameter int NNZ_W   = 16,
   parameter int VEC_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_rvalid,
   input  logic [PAIR_W-1:0] pair_rdata,
   output logic              vec_en,
   output logic [COL_W-1:0]  vec_addr,
   input  logic [VEC_W-1:0]  vec_rdata,
   input  logic [NNZ_W-1:0]  tag_label,
   input  logic              tag_empty,
   input  logic              tag_last,
   output logic              out_valid,
   output logic [VAL_W-1:0]  out_value,
   output logic [VEC_W-1:0]  out_vec,
   output logic [NNZ_W-1:0]  out_label,
   output logic              out_empty,
   output logic              out_done
);

   localparam int HOLD_W = VAL_W + 1;

   // Returned beats alternate: column half first, value half second.
   logic phase_q;
   logic val_beat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           phase_q <= 1'b0;
      else if (pair_rvalid) phase_q <= ~phase_q;
   end

   assign vec_en   = pair_rvalid && !phase_q;
   assign vec_addr = pair_rdata[COL_W-1:0];
   assign val_beat = pair_rvalid && phase_q;

   // Value waits for the vector RAM beyond the one cycle it already trails.
   logic [HOLD_W-1:0] hold_in, hold_out;
   assign hold_in = {val_beat, pair_rdata[VAL_W-1:0]};

   if (VEC_LAT == 1) begin : g_hold_none
      assign hold_out = hold_in;
   end else begin : g_hold_pipe
      csr_delay_line #(.W(HOLD_W), .DEPTH(VEC_LAT - 1)) u_hold (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (hold_in),
         .q     (hold_out)
      );
   end

   logic             val_v;
   logic [VAL_W-1:0] val_d;
   assign val_v = hold_out[HOLD_W-1];
   assign val_d = hold_out[VAL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_value <= '0;
         out_vec   <= '0;
         out_label <= '0;
         out_empty <= 1'b0;
         out_done  <= 1'b0;
      end else begin
         out_valid <= val_v || tag_empty;
         out_value <= tag_empty ? '0 : val_d;
         out_vec   <= tag_empty ? '0 : vec_rdata;
         out_label <= tag_label;
         out_empty <= tag_empty;
         out_done  <= tag_last && (val_v || tag_empty);
      end
   end

endmodule

// File: rtl/csr_stream_fetch.sv
module csr_stream_fetch #(
   parameter int ROW_W    = 8,
   parameter int NNZ_W    = 16,
   parameter int COL_W    = 12,
   parameter int VAL_W    = 32,
   parameter int VEC_W    = 32,
   parameter int PAIR_W   = 32,
   parameter int PAIR_LAT = 10,
   parameter int VEC_LAT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ROW_W-1:0]  num_rows,
   output logic              ptr_en,
   output logic [ROW_W-1:0]  ptr_addr,
   input  logic [NNZ_W-1:0]  ptr_rdata,
   output logic              pair_en,
   output logic              pair_sel,
   output logic [NNZ_W-1:0]  pair_addr,
   input  logic              pair_rvalid,
   input  logic [PAIR_W-1:0] pair_rdata,
   output logic              vec_en,
   output logic [COL_W-1:0]  vec_addr,
   input  logic [VEC_W-1:0]  vec_rdata,
   output logic              out_valid,
   output logic [VAL_W-1:0]  out_value,
   output logic [VEC_W-1:0]  out_vec,
   output logic [NNZ_W-1:0]  out_label,
   output logic              out_empty,
   output logic              out_done
);

   // Tag travels from the column issue to the cycle value and vector meet.
   localparam int TAG_DEPTH = PAIR_LAT + VEC_LAT;
   localparam int TAG_W     = NNZ_W + 2;

   if (PAIR_LAT < 1) begin : g_bad_pair_lat
      $error("csr_stream_fetch: PAIR_LAT must be at least 1");
   end
   if (VEC_LAT < 1) begin : g_bad_vec_lat
      $error("csr_stream_fetch: VEC_LAT must be at least 1");
   end
   if (PAIR_W < VAL_W || PAIR_W < COL_W) begin : g_bad_pair_w
      $error("csr_stream_fetch: PAIR_W must hold both value and column");
   end
   if (ROW_W < 1 || NNZ_W < 2) begin : g_bad_widths
      $error("csr_stream_fetch: ROW_W or NNZ_W too small");
   end

   logic [NNZ_W-1:0] seq_label, dly_label;
   logic             seq_empty, dly_empty;
   logic             seq_last,  dly_last;
   logic [TAG_W-1:0] tag_in, tag_out;

   csr_row_seq #(.ROW_W(ROW_W), .NNZ_W(NNZ_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .num_rows  (num_rows),
      .ptr_en    (ptr_en),
      .ptr_addr  (ptr_addr),
      .ptr_rdata (ptr_rdata),
      .pair_en   (pair_en),
      .pair_sel  (pair_sel),
      .pair_addr (pair_addr),
      .tag_label (seq_label),
      .tag_empty (seq_empty),
      .tag_last  (seq_last)
   );

   assign tag_in = {seq_last, seq_empty, seq_label};

   csr_delay_line #(.W(TAG_W), .DEPTH(TAG_DEPTH)) u_tag_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (tag_in),
      .q     (tag_out)
   );

   assign dly_last  = tag_out[TAG_W-1];
   assign dly_empty = tag_out[TAG_W-2];
   assign dly_label = tag_out[NNZ_W-1:0];

   csr_pair_align #(
      .PAIR_W  (PAIR_W),
      .COL_W   (COL_W),
      .VAL_W   (VAL_W),
      .VEC_W   (VEC_W),
      .NNZ_W   (NNZ_W),
      .VEC_LAT (VEC_LAT)
   ) u_align (
      .clk         (clk),
      .rst_n       (rst_n),
      .pair_rvalid (pair_rvalid),
      .pair_rdata  (pair_rdata),
      .vec_en      (vec_en),
      .vec_addr    (vec_addr),
      .vec_rdata   (vec_rdata),
      .tag_label   (dly_label),
      .tag_empty   (dly_empty),
      .tag_last    (dly_last),
      .out_valid   (out_valid),
      .out_value   (out_value),
      .out_vec     (out_vec),
      .out_label   (out_label),
      .out_empty   (out_empty),
      .out_done    (out_done)
   );

endmodule

// File: rtl/csr_stream_fetch_chk.sv
module csr_stream_fetch_chk #(
   parameter int ROW_W = 8,
   parameter int NNZ_W = 16,
   parameter int VAL_W = 32,
   parameter int VEC_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ptr_en,
   input logic [ROW_W-1:0] ptr_addr,
   input logic             pair_en,
   input logic             pair_sel,
   input logic [NNZ_W-1:0] pair_addr,
   input logic             pair_rvalid,
   input logic             vec_en,
   input logic             out_valid,
   input logic [VAL_W-1:0] out_value,
   input logic [VEC_W-1:0] out_vec,
   input logic [NNZ_W-1:0] out_label,
   input logic             out_empty,
   input logic             out_done
);

   AST_COL_THEN_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en && !pair_sel) |=> (pair_en && pair_sel && $stable(pair_addr))); // R4

   AST_VAL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_en && pair_sel) |=> !(pair_en && pair_sel)); // R7

   AST_VEC_THEN_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      vec_en |=> pair_rvalid); // R4

   AST_PTR_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ptr_en) |=> (ptr_en && (ptr_addr == $past(ptr_addr) + 1'b1))); // R3

   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_empty) |-> (out_value == '0 && out_vec == '0
                                    && out_label == NNZ_W'(1))); // R6

   AST_LABEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_label != '0)); // R5

   AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |-> out_valid); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_done |=> !out_done); // R9

endmodule

bind csr_stream_fetch csr_stream_fetch_chk #(
   .ROW_W (ROW_W),
   .NNZ_W (NNZ_W),
   .VAL_W (VAL_W),
   .VEC_W (VEC_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ptr_en      (ptr_en),
   .ptr_addr    (ptr_addr),
   .pair_en     (pair_en),
   .pair_sel    (pair_sel),
   .pair_addr   (pair_addr),
   .pair_rvalid (pair_rvalid),
   .vec_en      (vec_en),
   .out_valid   (out_valid),
   .out_value   (out_value),
   .out_vec     (out_vec),
   .out_label   (out_label),
   .out_empty   (out_empty),
   .out_done    (out_done)
);

// File: tb/tb_csr_stream_fetch.sv
module tb_csr_stream_fetch;

   localparam int ROW_W  = 4;
   localparam int NNZ_W  = 6;
   localparam int COL_W  = 4;
   localparam int VAL_W  = 16;
   localparam int VEC_W  = 16;
   localparam int PAIR_W = 16;
   localparam int PLAT   = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [ROW_W-1:0]  num_rows = '0;
   logic              ptr_en;
   logic [ROW_W-1:0]  ptr_addr;
   logic [NNZ_W-1:0]  ptr_rdata;
   logic              pair_en, pair_sel;
   logic [NNZ_W-1:0]  pair_addr;
   logic              pair_rvalid;
   logic [PAIR_W-1:0] pair_rdata;
   logic              vec_en;
   logic [COL_W-1:0]  vec_addr;
   logic [VEC_W-1:0]  vec_rdata;
   logic              out_valid, out_empty, out_done;
   logic [VAL_W-1:0]  out_value;
   logic [VEC_W-1:0]  out_vec;
   logic [NNZ_W-1:0]  out_label;

   always #5 clk = ~clk;

   csr_stream_fetch #(
      .ROW_W(ROW_W), .NNZ_W(NNZ_W), .COL_W(COL_W), .VAL_W(VAL_W),
      .VEC_W(VEC_W), .PAIR_W(PAIR_W), .PAIR_LAT(PLAT), .VEC_LAT(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .num_rows(num_rows),
      .ptr_en(ptr_en), .ptr_addr(ptr_addr), .ptr_rdata(ptr_rdata),
      .pair_en(pair_en), .pair_sel(pair_sel), .pair_addr(pair_addr),
      .pair_rvalid(pair_rvalid), .pair_rdata(pair_rdata),
      .vec_en(vec_en), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
      .out_valid(out_valid), .out_value(out_value), .out_vec(out_vec),
      .out_label(out_label), .out_empty(out_empty), .out_done(out_done)
   );

   // Memory models
   logic [NNZ_W-1:0] ptr_mem [16];
   logic [VAL_W-1:0] val_mem [64];
   logic [COL_W-1:0] col_mem [64];
   logic [VEC_W-1:0] vec_mem [16];

   always @(posedge clk) if (ptr_en) ptr_rdata <= ptr_mem[ptr_addr];
   always @(posedge clk) if (vec_en) vec_rdata <= vec_mem[vec_addr];

   logic             pq_v [PLAT];
   logic             pq_s [PLAT];
   logic [NNZ_W-1:0] pq_a [PLAT];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < PLAT; k++) begin
            pq_v[k] <= 1'b0; pq_s[k] <= 1'b0; pq_a[k] <= '0;
         end
      end else begin
         pq_v[0] <= pair_en; pq_s[0] <= pair_sel; pq_a[0] <= pair_addr;
         for (int k = 1; k < PLAT; k++) begin
            pq_v[k] <= pq_v[k-1]; pq_s[k] <= pq_s[k-1]; pq_a[k] <= pq_a[k-1];
         end
      end
   end

   assign pair_rvalid = pq_v[PLAT-1];
   assign pair_rdata  = !pq_v[PLAT-1] ? '0 :
                        pq_s[PLAT-1] ? val_mem[pq_a[PLAT-1]] :
                                       {{(PAIR_W-COL_W){1'b0}}, col_mem[pq_a[PLAT-1]]};

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   // Expected stream
   int lens_g [16];
   int e_val [64];
   int e_vec [64];
   int e_lbl [64];
   int e_emp [64];
   int e_cyc [64];
   int e_first [64];   // 1: first output of its row (R8), 0: follows in-row (R7)
   int e_n;

   task automatic run_matrix(input int run, input int nrows, input int base);
      int t, p, got, n0, lastc;
      for (int c = 0; c < 16; c++) vec_mem[c] = VEC_W'(16'hA000 + c * 11 + run * 3);
      e_n = 0;
      t = 5;
      p = base;
      ptr_mem[0] = NNZ_W'(base);
      for (int r = 0; r < nrows; r++) begin
         ptr_mem[r+1] = NNZ_W'(p + lens_g[r]);
         if (lens_g[r] == 0) begin
            e_val[e_n] = 0; e_vec[e_n] = 0; e_lbl[e_n] = 1; e_emp[e_n] = 1;
            e_cyc[e_n] = t + 12; e_first[e_n] = 1; e_n++;
            t += 4;
         end else begin
            for (int j = 0; j < lens_g[r]; j++) begin
               val_mem[p+j] = VAL_W'(16'h1000 + (p + j) * 37 + run * 5);
               col_mem[p+j] = COL_W'(((p + j) * 7 + run) % 16);
               e_val[e_n] = int'(val_mem[p+j]);
               e_vec[e_n] = int'(vec_mem[col_mem[p+j]]);
               e_lbl[e_n] = lens_g[r] - j;
               e_emp[e_n] = 0;
               e_cyc[e_n] = t + 12 + 2 * j;
               e_first[e_n] = (j == 0) ? 1 : 0;
               e_n++;
            end
            t += 2 * lens_g[r] + 3;
            p += lens_g[r];
         end
      end
      @(negedge clk);
      num_rows = ROW_W'(nrows);
      start = 1'b1;
      n0 = cyc;
      @(negedge clk);
      start = 1'b0;
      got = 0;
      lastc = e_cyc[e_n-1] + 15;
      while (cyc - n0 <= lastc) begin
         if (out_valid) begin
            if (got < e_n) begin
               chk(out_value == VAL_W'(e_val[got]), "R3", "value", out_value, e_val[got]);
               chk(out_vec == VEC_W'(e_vec[got]), "R4", "vector entry", out_vec, e_vec[got]);
               chk(out_label == NNZ_W'(e_lbl[got]), "R5", "label", out_label, e_lbl[got]);
               chk(out_empty == e_emp[got][0], "R6", "empty flag", out_empty, e_emp[got]);
               if (e_first[got] == 1)
                  chk(cyc - n0 == e_cyc[got], "R8", "row start cycle", cyc - n0, e_cyc[got]);
               else
                  chk(cyc - n0 == e_cyc[got], "R7", "in-row cycle", cyc - n0, e_cyc[got]);
               chk(out_done == (got == e_n - 1), "R9", "done flag", out_done,
                   (got == e_n - 1) ? 1 : 0);
            end else begin
               chk(1'b0, "R3", "extra output index", got, e_n);
            end
            got++;
         end
         @(negedge clk);
      end
      chk(got == e_n, "R3", "output count", got, e_n);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL R9 watchdog: got %0d expected %0d", 1, 0);
      report();
   end

   initial begin
      for (int k = 0; k < 64; k++) begin val_mem[k] = '0; col_mem[k] = '0; end
      for (int k = 0; k < 16; k++) begin ptr_mem[k] = '0; vec_mem[k] = '0; end
      repeat (4) @(negedge clk);
      // R1: quiet during and after reset
      chk(!out_valid && !out_done, "R1", "outputs in reset", out_valid, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!ptr_en && !pair_en && !vec_en, "R1", "reads after reset",
          {ptr_en, pair_en, vec_en}, 0);
      chk(!out_valid && !out_done, "R1", "outputs after reset",
          {out_valid, out_done}, 0);

      // R2: zero-row start is ignored
      num_rows = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      begin
         int seen = 0;
         for (int k = 0; k < 30; k++) begin
            if (ptr_en || pair_en || out_valid) seen++;
            @(negedge clk);
         end
         chk(seen == 0, "R2", "activity after zero-row start", seen, 0);
      end

      // Directed matrices
      lens_g[0] = 3; lens_g[1] = 1; lens_g[2] = 0; lens_g[3] = 4; lens_g[4] = 2;
      run_matrix(1, 5, 0);
      lens_g[0] = 0; lens_g[1] = 0; lens_g[2] = 2;
      run_matrix(2, 3, 3);
      lens_g[0] = 1;
      run_matrix(3, 1, 0);
      lens_g[0] = 5; lens_g[1] = 0;
      run_matrix(4, 2, 7);
      lens_g[0] = 0;
      run_matrix(5, 1, 0);

      // Sweep of two-row shapes
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            lens_g[0] = a; lens_g[1] = b;
            run_matrix(10 + a * 4 + b, 2, a + b);
         end
      end

      // Largest row count this configuration allows
      for (int r = 0; r < 15; r++) lens_g[r] = r % 4;
      run_matrix(40, 15, 2);

      report();
   end

endmodule